// File: doc/BRIEF.md
# Little-Endian Word Load/Store Unit

This block sits between a 16-bit processor core and a 4 KiB byte-addressed data memory that it holds internally. The core issues one request per cycle, either a word load or a word store, with the address taken from a base register. Each request moves a full 16-bit word in a single access. Little-endian placement applies: the even byte holds bits 7:0 and the next byte up holds bits 15:8.

The memory is built from one byte-wide lane per byte of the word, and all lanes are accessed together. Only the low 12 address bits select a byte. A request whose address is not word aligned is refused. The block raises an error flag, drops a store, and returns zero for a load. A parameter chooses whether reset also clears the memory contents.

Top module: `lsu_word_unit`

## Requirements
- R1: While `rst_n` is low across a clock edge, `rdata_o` becomes 0 and `misalign_o` becomes 0.
- R2: A load request (`req_i`=1, `we_i`=0) to an even address A puts on `rdata_o`, on the cycle after the request, the word whose bits 7:0 come from byte A and whose bits 15:8 come from byte A+1.
- R3: A store request (`req_i`=1, `we_i`=1) to an even address A writes `wdata_i[7:0]` to byte A and `wdata_i[15:8]` to byte A+1 in one cycle. A later aligned load of A returns the stored word.
- R4: `misalign_o` is 1 on the cycle after a request whose address bit 0 is 1, and 0 on the cycle after any other cycle.
- R5: A store request with address bit 0 set changes no byte of memory. Aligned loads of the neighbouring words return their earlier contents.
- R6: A load request with address bit 0 set drives `rdata_o` to 0 on the following cycle.
- R7: Address bits 15 down to 12 have no effect. An access to A and an access to A with any of those bits changed reach the same bytes.
- R8: On a cycle after a cycle with no load request (idle or store), `rdata_o` keeps its previous value.
- R9: With the clear-on-reset parameter set (the default), every byte reads as zero after reset, including bytes written before that reset.
- R10: Requests may arrive every cycle. A load issued on the cycle right after a store to the same address returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 16 | Byte address from the base register |
| wdata_i | input | 16 | Word to store |
| rdata_o | output | 16 | Loaded word, valid the cycle after a load |
| misalign_o | output | 1 | Alignment error for the previous cycle's request |

## Verification
The bench aims stores and loads at the first and last words of the space, and at addresses whose upper four bits are set. A design that decoded too many address bits would index out of range or alias the wrong word. It attempts stores at odd addresses next to known data. A design that wrote through anyway, or rounded the address down, would corrupt a neighbour that the following loads read back. It also runs load-after-store back to back and leaves idle gaps after loads. A late write or a read register that is not held would then return stale or vanishing data. A second reset after writes exposes a memory that fails to clear.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      LSU_IDLE  = 2'd0,
      LSU_LOAD  = 2'd1,
      LSU_STORE = 2'd2
   } lsu_op_e;

   function automatic int lane_count(input int data_w);
      return data_w / 8;
   endfunction

   function automatic lsu_op_e op_of(input logic req, input logic we);
      if (!req)    return LSU_IDLE;
      else if (we) return LSU_STORE;
      else         return LSU_LOAD;
   endfunction

endpackage

// File: rtl/lsu_addr_dec.sv
module lsu_addr_dec #(
   parameter int MEM_AW = 12,
   parameter int LANES  = 2
) (
   input  logic [MEM_AW-1:0]                 byte_addr,
   output logic [MEM_AW-$clog2(LANES)-1:0]   word_idx,
   output logic                              misalign
);
   localparam int LB = $clog2(LANES);

   assign word_idx = byte_addr[MEM_AW-1:LB];
   assign misalign = |byte_addr[LB-1:0];
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane #(
   parameter int IDX_W          = 11,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[idx] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (rst_n && wr_en) mem[idx] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[idx];
   end
endmodule

// File: rtl/lsu_word_unit.sv
module lsu_word_unit
   import lsu_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int ADDR_W         = 16,
   parameter int MEM_AW         = 12,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              misalign_o
);
   localparam int LANES = lane_count(DATA_W);
   localparam int LB    = $clog2(LANES);
   localparam int IDX_W = MEM_AW - LB;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16)
         $error("lsu_word_unit: DATA_W must be a multiple of 8, at least 16");
      if ((1 << LB) != LANES)
         $error("lsu_word_unit: lane count must be a power of two");
      if (ADDR_W <= MEM_AW)
         $error("lsu_word_unit: ADDR_W must exceed MEM_AW");
      if (IDX_W < 1)
         $error("lsu_word_unit: memory too small for word width");
   endgenerate

   logic             unused_addr_hi;
   logic [IDX_W-1:0] word_idx;
   logic             misalign;
   lsu_op_e          op;
   logic             load_ok;
   logic             store_ok;
   logic             err_q;
   logic             bad_load_q;
   logic [LANES-1:0][7:0] lane_rd;

   assign unused_addr_hi = ^addr_i[ADDR_W-1:MEM_AW];

   lsu_addr_dec #(
      .MEM_AW (MEM_AW),
      .LANES  (LANES)
   ) u_dec (
      .byte_addr (addr_i[MEM_AW-1:0]),
      .word_idx  (word_idx),
      .misalign  (misalign)
   );

   assign op       = op_of(req_i, we_i);
   assign load_ok  = (op == LSU_LOAD)  && !misalign;
   assign store_ok = (op == LSU_STORE) && !misalign;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      lsu_byte_lane #(
         .IDX_W          (IDX_W),
         .CLEAR_ON_RESET (CLEAR_ON_RESET)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (store_ok),
         .rd_en (load_ok),
         .idx   (word_idx),
         .wdata (wdata_i[8*k +: 8]),
         .rdata (lane_rd[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q      <= 1'b0;
         bad_load_q <= 1'b0;
      end else begin
         err_q <= req_i && misalign;
         if (op == LSU_LOAD) bad_load_q <= misalign;
      end
   end

   assign rdata_o    = bad_load_q ? '0 : DATA_W'(lane_rd);
   assign misalign_o = err_q;
endmodule

// File: rtl/lsu_word_unit_chk.sv
module lsu_word_unit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              we_i,
   input logic              addr_lsb,
   input logic [DATA_W-1:0] rdata_o,
   input logic              misalign_o
);
   a_r4_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && addr_lsb) |=> misalign_o);

   a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && addr_lsb) |=> !misalign_o);

   a_r6_bad_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i && addr_lsb) |=> (rdata_o == '0));

   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind lsu_word_unit lsu_word_unit_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .we_i       (we_i),
   .addr_lsb   (addr_i[0]),
   .rdata_o    (rdata_o),
   .misalign_o (misalign_o)
);

// File: tb/lsu_word_unit_tb.sv
module lsu_word_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        we_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        misalign_o;

   int total = 0;
   int bad = 0;

   typedef struct {
      logic [15:0] rd;
      logic        err;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [7:0]  mdl [4096];
   logic [15:0] exp_hold = '0;

   always #4 clk = ~clk;

   lsu_word_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .we_i       (we_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .misalign_o (misalign_o)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: compares one result per cycle against the queue
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (rdata_o !== e.rd || misalign_o !== e.err) begin
               bad++;
               $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                        e.tag, rdata_o, misalign_o, e.rd, e.err);
            end
         end
      end
   end

   // driver: one request per cycle, expected result from the model
   task automatic step(input bit rq, input bit we, input logic [15:0] a,
                       input logic [15:0] wd, input string tag);
      exp_t e;
      int   b;
      @(negedge clk);
      req_i   = rq;
      we_i    = we;
      addr_i  = a;
      wdata_i = wd;
      b = int'(a[11:0]);
      if (rq && !we) begin
         if (a[0]) exp_hold = '0;
         else      exp_hold = {mdl[b + 1], mdl[b]};
      end
      if (rq && we && !a[0]) begin
         mdl[b]     = wd[7:0];
         mdl[b + 1] = wd[15:8];
      end
      e.rd  = exp_hold;
      e.err = rq && a[0];
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic ld(input logic [15:0] a, input string tag);
      step(1'b1, 1'b0, a, 16'h0, tag);
   endtask

   task automatic st(input logic [15:0] a, input logic [15:0] d, input string tag);
      step(1'b1, 1'b1, a, d, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 16'h0, 16'h0, tag);
   endtask

   task automatic drain();
      idle("R8 drain");
      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_i = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (rdata_o !== 16'h0 || misalign_o !== 1'b0) begin
         bad++;
         $display("FAIL R1: rdata=%h err=%b expected rdata=0000 err=0",
                  rdata_o, misalign_o);
      end
      for (int i = 0; i < 4096; i++) mdl[i] = 8'h00;
      exp_hold = '0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL R10: watchdog expired, run hung");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mdl[i] = 8'h00;
      do_reset();

      // R9: cleared memory after reset
      ld(16'h0000, "R9");
      ld(16'h0ffe, "R9");
      ld(16'h0642, "R9");

      // R2 / R3: stores then loads at ends and middle of the space
      st(16'h0000, 16'hA55A, "R3");
      st(16'h0ffe, 16'h1234, "R3");
      st(16'h0100, 16'hBEEF, "R3");
      st(16'h0102, 16'h00FF, "R3");
      ld(16'h0000, "R2");
      ld(16'h0ffe, "R2");
      ld(16'h0100, "R2");
      ld(16'h0102, "R2");

      // R8: hold across idle and store cycles
      idle("R8");
      idle("R8");
      st(16'h0200, 16'h7777, "R8");
      idle("R8");

      // R10: back-to-back store then load of same address
      st(16'h0300, 16'hC0DE, "R10");
      ld(16'h0300, "R10");
      st(16'h0300, 16'hF00D, "R10");
      ld(16'h0300, "R10");
      for (int i = 0; i < 8; i++) begin
         st(16'(16'h0400 + 2 * i), 16'(16'h1111 * (i + 1)), "R10");
      end
      for (int i = 0; i < 8; i++) begin
         ld(16'(16'h0400 + 2 * i), "R10");
      end

      // R4 / R5: misaligned stores write nothing, flag error
      st(16'h0101, 16'h9999, "R5");
      st(16'h0fff, 16'h8888, "R5");
      ld(16'h0100, "R5");
      ld(16'h0102, "R5");
      ld(16'h0ffe, "R5");
      ld(16'h0000, "R5");
      idle("R4");

      // R6: misaligned load returns zero, then holds zero
      ld(16'h0101, "R6");
      idle("R6");
      ld(16'h0100, "R6");
      ld(16'h0303, "R6");
      st(16'h0305, 16'h4444, "R4");

      // R7: upper address bits ignored
      st(16'hF234, 16'h5AA5, "R7");
      ld(16'h0234, "R7");
      st(16'h1234, 16'h6116, "R7");
      ld(16'h8234, "R7");
      ld(16'hFFFE, "R7");

      drain();

      // R9: second reset clears written bytes
      do_reset();
      ld(16'h0100, "R9");
      ld(16'h0ffe, "R9");
      ld(16'h0234, "R9");
      drain();

      summary();
      $finish;
   end
endmodule